// File: doc/BRIEF.md
# Sorted Delta Timer Queue

This block keeps up to `N` pending timers in a short hardware list, sorted so that the timer due soonest sits at the front. Each slot stores only the number of ticks between its own expiry and the expiry of the slot in front of it. A tick therefore changes one count, the one at the front, and every later slot ages with it at no cost. When the front count is zero, the block offers that timer's ID on a valid/ready port. Slots behind it that also hold zero are offered on the following cycles.

The host installs a timer by giving a tick count and an ID, and it removes a timer by giving the ID. Both commands run as a walk of one slot per cycle. An install subtracts the counts it passes and then opens a gap at its slot by shifting the later slots down. A cancel searches for the ID, closes the gap, and adds the removed count to the slot that follows. While a walk runs, `busy` is high. Ticks that arrive while `busy` is high, or while an expired timer waits to be taken, are kept in a backlog counter. They are applied later, one per cycle.

Top module: `delta_timer_queue`

## Requirements
- R1: While `rst_n` is low, the list is empty and `busy`, `err` and `exp_valid` are all low.
- R2: With `busy` low, an install (`ins_valid` high, `ins_ticks` nonzero, list not full) holds `busy` high for p+1 cycles. Here p is the number of queued timers whose expiry falls at or before the new one. After those cycles the new ID is in the list and expires after exactly `ins_ticks` applied ticks.
- R3: Timers expire in ascending order of due time. Timers due on the same tick come out in the order they were installed.
- R4: An applied tick lowers the front timer's remaining count by one. Each later timer keeps its due time relative to the front. At most one tick is applied per cycle, and it takes effect at the same clock edge when `busy` is low, the list is not empty and the front timer has not expired.
- R5: `exp_valid` is high when `busy` is low and the front timer's remaining count is zero, with `exp_id` carrying its ID. The entry is removed at an edge where `exp_ready` is high. While `exp_ready` is low and no command is given, `exp_valid` and `exp_id` hold. Timers due on the same tick come out on consecutive cycles.
- R6: Ticks that arrive while `busy` is high or while the front timer waits are counted in a backlog that saturates at 2^PW-1. They are applied later, one per cycle. Ticks that arrive while `busy` is low and the list is empty are discarded.
- R7: A cancel (`cancel_valid` high, `busy` low, `ins_valid` low) removes the first queued timer with a matching ID. It holds `busy` high for p+1 cycles, where p is that timer's position counted from 0 at the front. The due times of all other timers do not change.
- R8: A cancel with no matching ID holds `busy` high for (list size)+1 cycles, leaves the list unchanged, and pulses `err` for one cycle as `busy` falls.
- R9: An install with `ins_ticks` equal to 0, or an install into a full list, is refused. `err` is high for the one cycle after the command, `busy` stays low, and the list is unchanged.
- R10: Commands given while `busy` is high are ignored. If an install and a cancel are given in the same cycle, only the install runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One timebase tick per cycle in which it is high |
| ins_valid | input | 1 | Install command |
| ins_ticks | input | CW | Delay of the new timer in ticks |
| ins_id | input | IW | ID of the new timer |
| cancel_valid | input | 1 | Cancel command |
| cancel_id | input | IW | ID of the timer to remove |
| busy | output | 1 | A walk is in progress; commands are ignored |
| err | output | 1 | One-cycle pulse for a refused install or a cancel that found no match |
| exp_valid | output | 1 | An expired timer is offered |
| exp_id | output | IW | ID of the expired timer |
| exp_ready | input | 1 | Host takes the offered expiry |

## Verification
The bench builds the block with a four-slot list, 8-bit counts, 4-bit IDs and a 4-bit tick backlog. With only four slots, the full-list refusal, installs at every position and ID collisions all come up often under random commands. The 4-bit backlog can reach saturation when expiries are held back. A short delay range makes many timers fall due on the same tick, which exercises the chains of back-to-back expiries and inserts placed behind equal entries.

// File: rtl/delta_timer_queue.sv
module delta_timer_queue #(
  parameter int N  = 8,
  parameter int CW = 16,
  parameter int IW = 6,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ins_valid,
  input  logic [CW-1:0] ins_ticks,
  input  logic [IW-1:0] ins_id,
  input  logic          cancel_valid,
  input  logic [IW-1:0] cancel_id,
  output logic          busy,
  output logic          err,
  output logic          exp_valid,
  output logic [IW-1:0] exp_id,
  input  logic          exp_ready
);
  localparam int XW = $clog2(N + 1);
  localparam int AW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_INS, S_CAN} st_t;

  st_t           st;
  logic [CW-1:0] cnt [N];
  logic [IW-1:0] ids [N];
  logic [XW-1:0] occ, idx;
  logic [CW-1:0] rem;
  logic [IW-1:0] key;
  logic [PW-1:0] pend, pend_nx;

  wire          at_end   = (idx == occ);
  wire [AW-1:0] ix       = idx[AW-1:0];
  wire [CW-1:0] cur      = cnt[ix];
  wire          head_exp = (occ != '0) && (cnt[0] == '0);
  wire          pop      = exp_valid && exp_ready;
  wire          take_ins = !busy && ins_valid;
  wire          take_can = !busy && cancel_valid && !ins_valid;
  wire          refuse   = take_ins && ((ins_ticks == '0) || (occ == XW'(N)));
  wire [PW:0]   eff      = {1'b0, pend} + (PW+1)'(tick);
  wire [PW-1:0] eff_sat  = eff[PW] ? '1 : eff[PW-1:0];
  wire          do_dec   = !busy && !head_exp && (occ != '0) && (eff_sat != '0);

  assign busy      = (st != S_IDLE);
  assign exp_valid = !busy && head_exp;
  assign exp_id    = ids[0];

  always_comb begin
    if (busy || head_exp)     pend_nx = eff_sat;
    else if (occ == '0)       pend_nx = '0;
    else if (eff_sat != '0)   pend_nx = eff_sat - 1'b1;
    else                      pend_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      occ  <= '0;
      idx  <= '0;
      rem  <= '0;
      key  <= '0;
      pend <= '0;
      err  <= 1'b0;
      for (int k = 0; k < N; k++) begin
        cnt[k] <= '0;
        ids[k] <= '0;
      end
    end else begin
      err  <= 1'b0;
      pend <= pend_nx;
      case (st)
        S_IDLE: begin
          if (pop) begin
            for (int k = 0; k < N - 1; k++) begin
              cnt[k] <= cnt[k+1];
              ids[k] <= ids[k+1];
            end
            occ <= occ - 1'b1;
          end else if (do_dec) begin
            cnt[0] <= cnt[0] - 1'b1;
          end
          idx <= '0;
          if (refuse) begin
            err <= 1'b1;
          end else if (take_ins) begin
            st  <= S_INS;
            rem <= ins_ticks;
            key <= ins_id;
          end else if (take_can) begin
            st  <= S_CAN;
            key <= cancel_id;
          end
        end
        S_INS: begin
          if (at_end || rem < cur) begin
            for (int k = 1; k < N; k++) begin
              if (k > int'(idx) && k <= int'(occ)) begin
                cnt[k] <= cnt[k-1];
                ids[k] <= ids[k-1];
              end
              if (k == int'(idx) + 1 && !at_end) cnt[k] <= cur - rem;
            end
            cnt[ix] <= rem;
            ids[ix] <= key;
            occ     <= occ + 1'b1;
            st      <= S_IDLE;
          end else begin
            rem <= rem - cur;
            idx <= idx + 1'b1;
          end
        end
        S_CAN: begin
          if (at_end) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else if (ids[ix] == key) begin
            for (int k = 0; k < N - 1; k++) begin
              if (k >= int'(idx)) begin
                ids[k] <= ids[k+1];
                cnt[k] <= (k == int'(idx)) ? cnt[k+1] + cur : cnt[k+1];
              end
            end
            occ <= occ - 1'b1;
            st  <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/delta_timer_queue_chk.sv
module delta_timer_queue_chk #(
  parameter int N  = 8,
  parameter int CW = 16,
  parameter int IW = 6,
  parameter int PW = 8,
  parameter int XW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ins_valid,
  input logic [CW-1:0] ins_ticks,
  input logic          cancel_valid,
  input logic          busy,
  input logic          err,
  input logic          exp_valid,
  input logic [IW-1:0] exp_id,
  input logic          exp_ready,
  input logic [XW-1:0] occ,
  input logic [PW-1:0] pend
);
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= N);

  p_full_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ins_valid && int'(occ) == N |=> err && !busy);

  p_zero_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ins_valid && ins_ticks == '0 |=> err && !busy);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid && !exp_ready && !ins_valid && !cancel_valid |=> exp_valid && $stable(exp_id));

  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid && exp_ready |=> occ == $past(occ) - 1'b1);

  p_tick_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && pend != {PW{1'b1}} |=> pend == $past(pend) + 1'b1);

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$rose(err) || !busy);
endmodule

bind delta_timer_queue delta_timer_queue_chk #(.N(N), .CW(CW), .IW(IW), .PW(PW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ins_valid(ins_valid), .ins_ticks(ins_ticks),
  .cancel_valid(cancel_valid), .busy(busy), .err(err), .exp_valid(exp_valid),
  .exp_id(exp_id), .exp_ready(exp_ready), .occ(occ), .pend(pend)
);

// File: tb/test_delta_timer_queue.sv
module test_delta_timer_queue;
  localparam int N = 4, CW = 8, IW = 4, PW = 4, PMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, exp_ready = 1'b0;
  logic ins_valid = 1'b0, cancel_valid = 1'b0;
  logic [CW-1:0] ins_ticks = '0;
  logic [IW-1:0] ins_id = '0, cancel_id = '0;
  logic busy, err, exp_valid;
  logic [IW-1:0] exp_id;

  always #5 clk = ~clk;

  delta_timer_queue #(.N(N), .CW(CW), .IW(IW), .PW(PW)) i_delta_timer_queue (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ins_valid(ins_valid), .ins_ticks(ins_ticks),
    .ins_id(ins_id), .cancel_valid(cancel_valid), .cancel_id(cancel_id), .busy(busy),
    .err(err), .exp_valid(exp_valid), .exp_id(exp_id), .exp_ready(exp_ready));

  int vectors = 0, miscompares = 0;
  string tag = "R1";
  int tick_pct = 0, rdy_pct = 100;
  bit finished = 0;

  // behavioural reference: absolute due times against an applied-tick clock
  int dl[$], qid[$], seen[$];
  int a_m = 0, pt_m = 0, bcnt = 0, op_t = 0, op_id = 0;
  bit busy_m = 0, err_m = 0, op_can = 0;

  function automatic int ins_pos(int target);
    int p = 0;
    foreach (dl[k]) if (dl[k] <= target) p++;
    return p;
  endfunction

  function automatic int can_pos(int id);
    foreach (qid[k]) if (qid[k] == id) return k;
    return qid.size();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      dl.delete(); qid.delete();
      a_m = 0; pt_m = 0; busy_m = 0; err_m = 0; bcnt = 0;
    end else begin
      automatic bit expv = !busy_m && dl.size() > 0 && dl[0] == a_m;
      automatic int eff  = pt_m + int'(tick);
      automatic int sz0  = dl.size();
      automatic bit nerr = 0;
      automatic int p    = 0;
      if (eff > PMAX) eff = PMAX;
      if (busy_m) begin
        pt_m = eff;
        bcnt--;
        if (bcnt == 0) begin
          busy_m = 0;
          if (!op_can) begin
            p = ins_pos(a_m + op_t);
            dl.insert(p, a_m + op_t);
            qid.insert(p, op_id);
          end else begin
            p = can_pos(op_id);
            if (p < qid.size()) begin dl.delete(p); qid.delete(p); end
            else nerr = 1;
          end
        end
      end else begin
        if (expv) begin
          pt_m = eff;
          if (exp_ready) begin void'(dl.pop_front()); void'(qid.pop_front()); end
        end else if (sz0 == 0) pt_m = 0;
        else if (eff > 0) begin a_m++; pt_m = eff - 1; end
        else pt_m = 0;
        if (ins_valid) begin
          if (ins_ticks == '0 || sz0 == N) nerr = 1;
          else begin
            op_can = 0; op_t = int'(ins_ticks); op_id = int'(ins_id);
            busy_m = 1; bcnt = ins_pos(a_m + op_t) + 1;
          end
        end else if (cancel_valid) begin
          op_can = 1; op_id = int'(cancel_id);
          busy_m = 1; bcnt = can_pos(op_id) + 1;
        end
      end
      err_m = nerr;
    end
  end

  always @(posedge clk) if (rst_n && exp_valid && exp_ready) seen.push_back(int'(exp_id));

  always @(posedge clk) begin
    #2;
    tick      = ($urandom_range(99) < tick_pct);
    exp_ready = ($urandom_range(99) < rdy_pct);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(busy == busy_m, {tag, " busy"}, busy, busy_m);
    chk(err == err_m, {tag, " err"}, err, err_m);
    chk(exp_valid == (!busy_m && dl.size() > 0 && dl[0] == a_m), {tag, " exp_valid"}, exp_valid,
        !busy_m && dl.size() > 0 && dl[0] == a_m);
    if (exp_valid && qid.size() > 0) chk(int'(exp_id) == qid[0], {tag, " exp_id"}, exp_id, qid[0]);
  end

  task automatic idle_wait();
    while (busy_m) @(negedge clk);
  endtask

  task automatic issue(bit iv, int t, int id, bit cv, int cid);
    @(negedge clk);
    idle_wait();
    ins_valid = iv; ins_ticks = CW'(t); ins_id = IW'(id);
    cancel_valid = cv; cancel_id = IW'(cid);
    @(negedge clk);
    ins_valid = 0; cancel_valid = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic put(int t, int id);
    int n;
    issue(1, t, id, 0, 0);
    busy_len(n);
  endtask

  task automatic cancel(int id, output int n, output bit e);
    issue(0, 0, 0, 1, id);
    busy_len(n);
    e = err;
  endtask

  initial begin
    int n;
    bit e;
    repeat (3) @(negedge clk);
    chk(busy == 0 && err == 0 && exp_valid == 0, "R1 reset outputs", {busy, err, exp_valid}, 0);
    rst_n = 1;

    tag = "R3";
    put(5, 1); put(3, 2); put(5, 3); put(1, 4);
    seen.delete();
    tick_pct = 100;
    repeat (14) @(negedge clk);
    tick_pct = 0;
    chk(seen.size() == 4, "R3 expiry count", seen.size(), 4);
    if (seen.size() == 4) begin
      chk(seen[0] == 4, "R3 order 0", seen[0], 4);
      chk(seen[1] == 2, "R3 order 1", seen[1], 2);
      chk(seen[2] == 1, "R3 order 2 tie", seen[2], 1);
      chk(seen[3] == 3, "R3 order 3 tie", seen[3], 3);
    end
    repeat (3) @(negedge clk);

    tag = "R4";
    put(3, 5); put(6, 6);
    @(negedge clk);
    tick_pct = 100;
    n = 0;
    while (!exp_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, "R4 head expires after three ticks", n, 4);
    chk(exp_id == 5, "R4 head id", exp_id, 5);
    repeat (12) @(negedge clk);
    tick_pct = 0;
    repeat (3) @(negedge clk);

    tag = "R6";
    rdy_pct = 0; tick_pct = 100;
    put(2, 7); put(2, 8); put(4, 9);
    repeat (10) @(negedge clk);
    chk(exp_valid == 1, "R5 expiry held while not ready", exp_valid, 1);
    chk(exp_id == 7, "R5 held id", exp_id, 7);
    seen.delete();
    tick_pct = 0; rdy_pct = 100;
    repeat (15) @(negedge clk);
    chk(seen.size() == 3, "R6 backlog drains all", seen.size(), 3);
    if (seen.size() == 3) chk(seen[0] == 7 && seen[1] == 8 && seen[2] == 9, "R6 order", seen[2], 9);
    tick_pct = 100;
    repeat (5) @(negedge clk);
    tick_pct = 0;
    repeat (2) @(negedge clk);
    put(3, 10);
    repeat (5) @(negedge clk);
    chk(exp_valid == 0, "R6 ticks on empty list discarded", exp_valid, 0);

    tag = "R7";
    cancel(10, n, e);
    chk(e == 0, "R7 cancel found", e, 0);
    put(4, 11); put(6, 12); put(9, 13);
    cancel(12, n, e);
    chk(n == 2, "R7 cancel walk length", n, 2);
    tag = "R8";
    cancel(14, n, e);
    chk(n == 3, "R8 miss walk length", n, 3);
    chk(e == 1, "R8 miss error", e, 1);
    tag = "R7";
    seen.delete();
    tick_pct = 100;
    repeat (16) @(negedge clk);
    tick_pct = 0;
    chk(seen.size() == 2, "R7 survivors expire", seen.size(), 2);
    if (seen.size() == 2) chk(seen[0] == 11 && seen[1] == 13, "R7 survivor order", seen[1], 13);
    repeat (3) @(negedge clk);

    tag = "R9";
    issue(1, 0, 3, 0, 0);
    chk(err == 1 && busy == 0, "R9 zero delay refused", {err, busy}, 2);
    put(20, 1); put(20, 2); put(20, 3); put(20, 4);
    issue(1, 5, 5, 0, 0);
    chk(err == 1 && busy == 0, "R9 full list refused", {err, busy}, 2);
    for (int k = 1; k <= 4; k++) begin
      cancel(k, n, e);
      chk(e == 0, "R9 list unchanged by refusal", e, 0);
    end

    tag = "R10";
    issue(1, 10, 1, 0, 0);
    cancel_valid = 1; cancel_id = 1;
    @(negedge clk);
    cancel_valid = 0;
    idle_wait();
    cancel(1, n, e);
    chk(e == 0, "R10 cancel during busy ignored", e, 0);
    issue(1, 10, 2, 1, 2);
    idle_wait();
    @(negedge clk);
    chk(err == 0, "R10 install wins over cancel", err, 0);
    cancel(2, n, e);
    chk(e == 0, "R10 installed entry present", e, 0);

    tag = "R2";
    @(negedge clk);
    issue(1, 7, 3, 0, 0);
    busy_len(n);
    chk(n == 1, "R2 install into empty list walk length", n, 1);
    tick_pct = 30; rdy_pct = 80;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      ins_valid    = ($urandom_range(99) < 15);
      ins_ticks    = CW'($urandom_range(19));
      ins_id       = IW'($urandom_range(15));
      cancel_valid = ($urandom_range(99) < 8);
      cancel_id    = IW'($urandom_range(15));
    end
    @(negedge clk);
    ins_valid = 0; cancel_valid = 0;
    repeat (20) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog %s: got %0d expected %0d", tag, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule